// File: doc/BRIEF.md
# Oversampled Serial Receiver with Two-Word Status FIFO

This block receives asynchronous serial characters from a single input line and places each finished character in a two-entry holding queue. The line is watched at sixteen samples per bit. A start bit is accepted, and each data bit and the stop bit is decided, by a two-of-three vote over the three samples around the middle of the bit. Characters carry 8 data bits, or 9 when the nine-bit mode is selected. The bits arrive least significant first, after a low start bit and before a stop bit that should be high.

Each queue entry holds the data together with its own ninth bit and framing-error flag. The status outputs always describe the oldest unread word, which is the same word shown on the data output. Reading pops that word, and the status outputs then move to the next entry. Software must therefore take the status before it reads the data. The bit rate is the system clock divided by a prescale of 16 or 64 and then by the 8-bit divisor value plus one.

A data-available flag, and an interrupt output gated by an enable, report that the queue holds words. If a third complete word arrives while both entries are full, that word is discarded and a sticky overrun flag is set. From then on the receiver ignores the line until the receive enable is lowered and raised again.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset, avail, irq and overrun are 0, and data_out, stat_bit9 and stat_ferr are 0.
- R2: A word is captured only while port_en and rx_en are both 1. A frame sent while either is 0 leaves avail at 0.
- R3: In 8-bit mode (nine_bit=0) a frame has a start bit of 0, then 8 data bits with the LSB first, then a stop bit. The word appears on data_out with stat_bit9=0.
- R4: In 9-bit mode (nine_bit=1) the ninth received bit follows bit 7 on the line and is presented on stat_bit9 together with its word.
- R5: Each bit is decided by the majority of samples 7, 8 and 9 of its 16 samples. A single-sample glitch at sample 8 does not change the received bit. A low pulse on an idle line that is shorter than 7 samples does not start a frame.
- R6: A stop bit decided as 0 stores the word with stat_ferr=1. The word is still delivered.
- R7: The queue holds two words, each with its own ninth bit and framing flag. A pulse on rd_data pops the head, and data_out, stat_bit9 and stat_ferr then show the next entry.
- R8: avail is 1 whenever the queue holds a word and goes to 0 only when reads empty it. irq equals avail AND int_en.
- R9: If a word completes while the queue is full, that word is dropped and overrun is set. While overrun is 1, no word enters the queue. The words already held stay readable in order.
- R10: Driving rx_en to 0 clears overrun. After rx_en returns to 1, reception resumes.
- R11: A read pulse while the queue is empty changes nothing, and data_out keeps the last word read.
- R12: One bit lasts 16*(divisor+1) clocks with fast_rate=1, and 64*(divisor+1) clocks with fast_rate=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port enable |
| rx_en | input | 1 | Continuous receive enable; a low level clears overrun |
| nine_bit | input | 1 | 1 selects 9 data bits per frame |
| fast_rate | input | 1 | 1 selects prescale 16, 0 selects prescale 64 |
| divisor | input | 8 | Bit-rate divisor; the rate is divided by divisor+1 |
| rx_in | input | 1 | Serial receive line, idle high |
| rd_data | input | 1 | One-cycle read strobe that pops the head word |
| int_en | input | 1 | Interrupt enable mask |
| data_out | output | 8 | Head word data, or the last word read when the queue is empty |
| stat_bit9 | output | 1 | Ninth bit of the head word |
| stat_ferr | output | 1 | Framing error of the head word |
| avail | output | 1 | Queue holds at least one word |
| irq | output | 1 | avail AND int_en |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The bench sends walking, all-zero, all-one, single-bit-at-each-end and alternating data words. These patterns distinguish LSB-first ordering from reversed ordering and expose stuck or swapped bit lanes. Nine-bit frames with the ninth bit at 1 and then at 0, together with a frame that has a low stop bit placed between good frames, show whether status travels with its own word or leaks to its neighbour. A one-clock glitch at mid-bit and a short false start test the vote. Three and four back-to-back frames sent without reads expose overrun handling and the order of the kept words. Frames at a larger divisor and at the slow prescale confirm the bit timing.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
   localparam int unsigned WORD_W = 8;

   typedef struct packed {
      logic              ninth;
      logic              frame_err;
      logic [WORD_W-1:0] data;
   } rx_word_t;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_STOP
   } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain;
         logic [STAGES:0]   chain_w;
         assign chain_w = {chain, d};
         always_ff @(posedge clk) begin
            if (!rst_n) chain <= '1;
            else        chain <= chain_w[STAGES-1:0];
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/rx_baud_gen.sv
module rx_baud_gen #(
   parameter int unsigned DIV_W    = 8,
   parameter int unsigned SUB_SLOW = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             slow,
   input  logic [DIV_W-1:0] divisor,
   output logic             tick
);
   localparam int unsigned SUB_W = (SUB_SLOW > 1) ? $clog2(SUB_SLOW) : 1;

   logic [DIV_W-1:0] div_cnt;
   logic [SUB_W-1:0] sub_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         div_cnt <= '0;
         sub_cnt <= '0;
         tick    <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (div_cnt >= divisor) begin
            div_cnt <= '0;
            if (!slow || sub_cnt == SUB_W'(SUB_SLOW - 1)) begin
               sub_cnt <= '0;
               tick    <= 1'b1;
            end else begin
               sub_cnt <= sub_cnt + 1'b1;
            end
         end else begin
            div_cnt <= div_cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/rx_shifter.sv
module rx_shifter
   import serial_rx_pkg::*;
#(
   parameter int unsigned OSR = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     run,
   input  logic     tick,
   input  logic     rx,
   input  logic     nine,
   output logic     done,
   output rx_word_t word
);
   localparam int unsigned CNT_W = $clog2(OSR);
   localparam int unsigned BIT_W = $clog2(WORD_W + 1);
   localparam logic [CNT_W-1:0] S_A  = CNT_W'(OSR / 2 - 1);
   localparam logic [CNT_W-1:0] S_B  = CNT_W'(OSR / 2);
   localparam logic [CNT_W-1:0] S_C  = CNT_W'(OSR / 2 + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

   rx_state_t         state;
   logic [CNT_W-1:0]  cnt;
   logic [BIT_W-1:0]  bitn;
   logic [BIT_W-1:0]  last_idx;
   logic [1:0]        vote;
   logic [WORD_W:0]   sr;
   logic              maj;

   assign maj      = (vote[1] & vote[0]) | (vote[1] & rx) | (vote[0] & rx);
   assign last_idx = nine ? BIT_W'(WORD_W) : BIT_W'(WORD_W - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         vote  <= 2'b11;
         sr    <= '0;
         done  <= 1'b0;
         word  <= '0;
      end else begin
         done <= 1'b0;
         if (!run) begin
            state <= ST_IDLE;
            cnt   <= '0;
            bitn  <= '0;
         end else if (tick) begin
            if (cnt == S_A) vote[0] <= rx;
            if (cnt == S_B) vote[1] <= rx;
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            case (state)
               ST_IDLE: begin
                  cnt <= '0;
                  if (!rx) begin
                     state <= ST_START;
                     cnt   <= CNT_W'(1);
                  end
               end
               ST_START: begin
                  if (cnt == S_C && maj) begin
                     state <= ST_IDLE;
                     cnt   <= '0;
                  end else if (cnt == LAST) begin
                     state <= ST_DATA;
                     bitn  <= '0;
                  end
               end
               ST_DATA: begin
                  if (cnt == S_C) sr[bitn] <= maj;
                  if (cnt == LAST) begin
                     if (bitn == last_idx) state <= ST_STOP;
                     else                  bitn  <= bitn + 1'b1;
                  end
               end
               ST_STOP: begin
                  if (cnt == S_C) begin
                     done            <= 1'b1;
                     word.ninth      <= nine & sr[WORD_W];
                     word.frame_err  <= ~maj;
                     word.data       <= sr[WORD_W-1:0];
                     state           <= ST_IDLE;
                     cnt             <= '0;
                  end
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end
endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
   import serial_rx_pkg::*;
#(
   parameter int unsigned DEPTH = 2,
   localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  rx_word_t         wdata,
   input  logic             pop,
   output rx_word_t         head,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty
);
   localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   rx_word_t         mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;
   logic             do_push, do_pop;

   function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign do_push = push & ~full;
   assign do_pop  = pop & ~empty;
   assign head    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_push) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (do_push) wr_ptr <= step(wr_ptr);
         if (do_pop)  rd_ptr <= step(rd_ptr);
         case ({do_push, do_pop})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo
   import serial_rx_pkg::*;
#(
   parameter int unsigned DIV_W       = 8,
   parameter int unsigned OSR         = 16,
   parameter int unsigned PRE_FAST    = 16,
   parameter int unsigned PRE_SLOW    = 64,
   parameter int unsigned DEPTH       = 2,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              rx_en,
   input  logic              nine_bit,
   input  logic              fast_rate,
   input  logic [DIV_W-1:0]  divisor,
   input  logic              rx_in,
   input  logic              rd_data,
   input  logic              int_en,
   output logic [WORD_W-1:0] data_out,
   output logic              stat_bit9,
   output logic              stat_ferr,
   output logic              avail,
   output logic              irq,
   output logic              overrun
);
   localparam int unsigned SUB_SLOW = PRE_SLOW / OSR;
   localparam int unsigned LVL_W    = $clog2(DEPTH + 1);

   generate
      if (OSR < 4) begin : g_bad_osr
         $error("OSR must be at least 4");
      end
      if (PRE_FAST != OSR) begin : g_bad_fast
         $error("PRE_FAST must equal OSR");
      end
      if (PRE_SLOW % OSR != 0 || PRE_SLOW < OSR) begin : g_bad_slow
         $error("PRE_SLOW must be a multiple of OSR");
      end
      if (DEPTH < 1) begin : g_bad_depth
         $error("DEPTH must be at least 1");
      end
   endgenerate

   logic             rx_s, tick, done, active, push, pop;
   logic             full, empty, ovr_q;
   logic [LVL_W-1:0] level;
   rx_word_t         rx_word, head, last_q, view;

   assign active = port_en & rx_en & ~ovr_q;
   assign push   = done & active & ~full;
   assign pop    = rd_data & ~empty;

   rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .d (rx_in), .q (rx_s)
   );

   rx_baud_gen #(.DIV_W(DIV_W), .SUB_SLOW(SUB_SLOW)) u_baud (
      .clk (clk), .rst_n (rst_n), .run (active), .slow (~fast_rate),
      .divisor (divisor), .tick (tick)
   );

   rx_shifter #(.OSR(OSR)) u_shift (
      .clk (clk), .rst_n (rst_n), .run (active), .tick (tick), .rx (rx_s),
      .nine (nine_bit), .done (done), .word (rx_word)
   );

   rx_word_fifo #(.DEPTH(DEPTH)) u_fifo (
      .clk (clk), .rst_n (rst_n), .push (push), .wdata (rx_word),
      .pop (pop), .head (head), .level (level), .full (full), .empty (empty)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovr_q  <= 1'b0;
         last_q <= '0;
      end else begin
         if (!rx_en)                      ovr_q <= 1'b0;
         else if (done && active && full) ovr_q <= 1'b1;
         if (pop) last_q <= head;
      end
   end

   assign view      = empty ? last_q : head;
   assign data_out  = view.data;
   assign stat_bit9 = view.ninth;
   assign stat_ferr = view.frame_err;
   assign avail     = ~empty;
   assign irq       = avail & int_en;
   assign overrun   = ovr_q;
endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk #(
   parameter int unsigned DEPTH = 2,
   parameter int unsigned LVL_W = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             port_en,
   input logic             rx_en,
   input logic             rd_data,
   input logic             int_en,
   input logic             avail,
   input logic             irq,
   input logic             overrun,
   input logic [7:0]       data_out,
   input logic [LVL_W-1:0] level
);
   // R7: occupancy never exceeds the queue depth
   a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   // R8: avail persists until a read
   a_r8_avail_holds: assert property (@(posedge clk) disable iff (!rst_n)
      avail && !rd_data |=> avail);

   a_r8_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !int_en |-> !irq);

   a_r8_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
      avail && int_en |-> irq);

   // R9: overrun is sticky while receive stays enabled, and blocks filling
   a_r9_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      overrun && rx_en |=> overrun);

   a_r9_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> level <= $past(level));

   // R10: dropping receive enable clears overrun
   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_en |=> !overrun);

   // R2: no new word while disabled
   a_r2_off_no_new: assert property (@(posedge clk) disable iff (!rst_n)
      !(port_en && rx_en) |=> !$rose(avail));

   // R11: empty read leaves the shown word alone
   a_r11_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data && !avail |=> $stable(data_out) || avail);
endmodule

bind serial_rx_fifo serial_rx_fifo_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk (clk), .rst_n (rst_n), .port_en (port_en), .rx_en (rx_en),
   .rd_data (rd_data), .int_en (int_en), .avail (avail), .irq (irq),
   .overrun (overrun), .data_out (data_out), .level (level)
);

// File: tb/serial_rx_fifo_tb.sv
module serial_rx_fifo_tb;
   logic       clk = 1'b0;
   logic       rst_n, port_en, rx_en, nine_bit, fast_rate, rx_in, rd_data, int_en;
   logic [7:0] divisor;
   logic [7:0] data_out;
   logic       stat_bit9, stat_ferr, avail, irq, overrun;

   int total = 0;
   int bad   = 0;
   int bit_clks = 16;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   serial_rx_fifo u_dut (
      .clk (clk), .rst_n (rst_n), .port_en (port_en), .rx_en (rx_en),
      .nine_bit (nine_bit), .fast_rate (fast_rate), .divisor (divisor),
      .rx_in (rx_in), .rd_data (rd_data), .int_en (int_en),
      .data_out (data_out), .stat_bit9 (stat_bit9), .stat_ferr (stat_ferr),
      .avail (avail), .irq (irq), .overrun (overrun)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic set_rate(input bit fast, input int dv);
      fast_rate = fast;
      divisor   = 8'(dv);
      bit_clks  = (fast ? 1 : 4) * (dv + 1) * 16;
   endtask

   task automatic drive_bit(input logic v, input bit glitch);
      for (int k = 0; k < bit_clks; k++) begin
         @(negedge clk);
         rx_in = (glitch && k == bit_clks / 2) ? ~v : v;
      end
   endtask

   task automatic send(input logic [8:0] w, input logic stop_v, input int glitch_at);
      drive_bit(1'b0, glitch_at == 0);
      for (int i = 0; i < (nine_bit ? 9 : 8); i++) drive_bit(w[i], glitch_at == i + 1);
      drive_bit(stop_v, 1'b0);
      drive_bit(1'b1, 1'b0);
   endtask

   task automatic read_word();
      @(negedge clk); rd_data = 1'b1;
      @(negedge clk); rd_data = 1'b0;
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 avail", int'(avail), 0);
      check("R1 irq", int'(irq), 0);
      check("R1 overrun", int'(overrun), 0);
      check("R1 data", int'({stat_bit9, stat_ferr, data_out}), 0);
   endtask

   task automatic t_basic();
      int pats[5] = '{8'hA5, 8'h00, 8'hFF, 8'h01, 8'h80};
      foreach (pats[i]) begin
         send(9'(pats[i]), 1'b1, -1);
         check("R3 data", int'(data_out), pats[i]);
         check("R3 bit9", int'(stat_bit9), 0);
         check("R8 avail", int'(avail), 1);
         int_en = 1'b1; @(negedge clk);
         check("R8 irq on", int'(irq), 1);
         int_en = 1'b0; @(negedge clk);
         check("R8 irq masked", int'(irq), 0);
         read_word();
         check("R8 avail cleared", int'(avail), 0);
      end
   endtask

   task automatic t_nine();
      nine_bit = 1'b1;
      send(9'h13C, 1'b1, -1);
      check("R4 ninth one", int'({stat_bit9, data_out}), 9'h13C);
      read_word();
      send(9'h0C3, 1'b1, -1);
      check("R4 ninth zero", int'({stat_bit9, data_out}), 9'h0C3);
      read_word();
      nine_bit = 1'b0;
   endtask

   task automatic t_enable();
      port_en = 1'b0;
      send(9'h5A, 1'b1, -1);
      check("R2 port off", int'(avail), 0);
      port_en = 1'b1; rx_en = 1'b0;
      send(9'h5A, 1'b1, -1);
      check("R2 rx off", int'(avail), 0);
      rx_en = 1'b1;
      send(9'h5A, 1'b1, -1);
      check("R2 both on", int'(data_out), 8'h5A);
      read_word();
   endtask

   task automatic t_vote();
      send(9'h55, 1'b1, 1);
      check("R5 glitch bit0", int'(data_out), 8'h55);
      read_word();
      send(9'h55, 1'b1, 4);
      check("R5 glitch bit3", int'(data_out), 8'h55);
      read_word();
      @(negedge clk); rx_in = 1'b0;
      repeat (3) @(negedge clk);
      rx_in = 1'b1;
      repeat (60) @(negedge clk);
      check("R5 false start", int'(avail), 0);
   endtask

   task automatic t_status_fifo();
      nine_bit = 1'b1;
      send(9'h13A, 1'b0, -1);
      send(9'h011, 1'b1, -1);
      check("R6 ferr head", int'(stat_ferr), 1);
      check("R6 data kept", int'({stat_bit9, data_out}), 9'h13A);
      read_word();
      check("R7 next status", int'({stat_ferr, stat_bit9}), 0);
      check("R7 next data", int'(data_out), 8'h11);
      read_word();
      nine_bit = 1'b0;
   endtask

   task automatic t_overrun();
      send(9'hA1, 1'b1, -1);
      send(9'hB2, 1'b1, -1);
      check("R9 no overrun at two", int'(overrun), 0);
      send(9'hC3, 1'b1, -1);
      check("R9 overrun set", int'(overrun), 1);
      send(9'hD4, 1'b1, -1);
      check("R9 still set", int'(overrun), 1);
      check("R9 head kept", int'(data_out), 8'hA1);
      read_word();
      check("R9 second kept", int'(data_out), 8'hB2);
      read_word();
      check("R9 emptied", int'(avail), 0);
      read_word();
      check("R11 empty read data", int'(data_out), 8'hB2);
      check("R11 empty read avail", int'(avail), 0);
      @(negedge clk); rx_en = 1'b0;
      @(negedge clk);
      check("R10 cleared", int'(overrun), 0);
      rx_en = 1'b1;
      send(9'hE5, 1'b1, -1);
      check("R10 resumed", int'(data_out), 8'hE5);
      read_word();
   endtask

   task automatic t_rates();
      set_rate(1'b1, 2);
      send(9'h96, 1'b1, -1);
      check("R12 divisor 2", int'(data_out), 8'h96);
      read_word();
      set_rate(1'b0, 0);
      send(9'h69, 1'b1, -1);
      check("R12 slow prescale", int'(data_out), 8'h69);
      read_word();
      set_rate(1'b1, 0);
   endtask

   initial begin
      rst_n = 1'b0; port_en = 1'b1; rx_en = 1'b1; nine_bit = 1'b0;
      rx_in = 1'b1; rd_data = 1'b0; int_en = 1'b0;
      set_rate(1'b1, 0);
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_nine();
      t_enable();
      t_vote();
      t_status_fifo();
      t_overrun();
      t_rates();
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule